// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry input and returns a 16-bit sum and a carry output, with no clock inside it. The operands are cut into four nibble-wide groups. Each group works out a generate and a propagate per bit, folds them into one group generate and one group propagate, and resolves its own internal carries with flat lookahead terms instead of a ripple chain.

A second lookahead level takes the four group pairs together with the carry input and produces the carry into each group directly. No carry ever walks from one group to the next. The group propagate and generate values also appear on two 4-bit outputs, so the tree can be inspected from outside the block.

Top module: `cla_adder16`

## Requirements
- R1: For every input, {cout, sum} equals the 17-bit arithmetic value a + b + cin.
- R2: Output grp_p[k] is 1 exactly when every bit position in nibble k (bits 4k+3 down to 4k) has a or b set, with the per-bit propagate taken as inclusive OR. Index 0 is the least significant nibble.
- R3: Output grp_g[k] is 1 exactly when nibble k of a added to nibble k of b, with no carry in, overflows 4 bits.
- R4: The carry into a nibble is 1 whenever the nibble below it has grp_g set, whatever cin is. It is 0 whenever the nibble below has both grp_g and grp_p clear. It equals the carry into the nibble below when that nibble has grp_p set and grp_g clear.
- R5: With a = 16'h1A33, b = 16'hE5EB and cin = 0, the outputs are grp_p = 4'b1110, grp_g = 4'b0010 (both written most significant nibble first), sum = 16'h001E and cout = 1.
- R6: The corner cases give the expected results. 16'hFFFF + 16'h0001 gives sum 0 with cout 1. 16'hFFFF + 0 with cin = 1 gives the same. 0 + 0 with cin = 0 gives sum 0 with cout 0.
- R7: When a bit has both operand bits set, its propagate term is still 1, yet the sum bit equals the carry into that bit. The sum is formed with XOR and never from the propagate term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Result bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_p | output | 4 | Group propagate, one bit per nibble |
| grp_g | output | 4 | Group generate, one bit per nibble |

## Verification
A group generate and a group propagate can both be set for the same nibble at the same time. This happens whenever a bit pair that generates sits below bit pairs that each propagate. In that case the second level must let the generate win regardless of the incoming carry. The bench provokes this with operands such as all-ones plus one, and with the worked example, where the second nibble has both flags set. It also repeats such operands with cin at 0 and at 1. Each result is judged against the behavioural 17-bit sum and against group flags computed from nibble arithmetic.

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4
) (
  input  logic [GROUP_W*GROUPS-1:0] a,
  input  logic [GROUP_W*GROUPS-1:0] b,
  input  logic                      cin,
  output logic [GROUP_W*GROUPS-1:0] sum,
  output logic                      cout,
  output logic [GROUPS-1:0]         grp_p,
  output logic [GROUPS-1:0]         grp_g
);
  localparam int W = GROUP_W * GROUPS;

  logic [W-1:0]    bit_g, bit_p;
  logic [GROUPS:0] gc;

  assign bit_g = a & b;
  assign bit_p = a | b;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    logic [GROUP_W-1:0] lg, lp;
    logic [GROUP_W-1:0] lc;
    assign lg = bit_g[k*GROUP_W +: GROUP_W];
    assign lp = bit_p[k*GROUP_W +: GROUP_W];

    always_comb begin
      logic gen_acc, term;
      grp_p[k] = &lp;
      gen_acc  = 1'b0;
      for (int j = 0; j < GROUP_W; j++) begin
        term = lg[j];
        for (int m = j + 1; m < GROUP_W; m++) term = term & lp[m];
        gen_acc = gen_acc | term;
      end
      grp_g[k] = gen_acc;
    end

    always_comb begin
      logic acc, term;
      lc[0] = gc[k];
      for (int i = 0; i < GROUP_W - 1; i++) begin
        acc = gc[k];
        for (int m = 0; m <= i; m++) acc = acc & lp[m];
        for (int j = 0; j <= i; j++) begin
          term = lg[j];
          for (int m = j + 1; m <= i; m++) term = term & lp[m];
          acc = acc | term;
        end
        lc[i+1] = acc;
      end
    end

    assign sum[k*GROUP_W +: GROUP_W] = a[k*GROUP_W +: GROUP_W] ^ b[k*GROUP_W +: GROUP_W] ^ lc;
  end

  always_comb begin
    logic acc, term;
    gc[0] = cin;
    for (int i = 0; i < GROUPS; i++) begin
      acc = cin;
      for (int m = 0; m <= i; m++) acc = acc & grp_p[m];
      for (int j = 0; j <= i; j++) begin
        term = grp_g[j];
        for (int m = j + 1; m <= i; m++) term = term & grp_p[m];
        acc = acc | term;
      end
      gc[i+1] = acc;
    end
  end

  assign cout = gc[GROUPS];
endmodule

module cla_adder16_chk #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4
) (
  input logic [GROUP_W*GROUPS-1:0] a,
  input logic [GROUP_W*GROUPS-1:0] b,
  input logic                      cin,
  input logic [GROUP_W*GROUPS-1:0] sum,
  input logic                      cout,
  input logic [GROUPS-1:0]         grp_p,
  input logic [GROUPS-1:0]         grp_g,
  input logic [GROUPS:0]           gc
);
  localparam int W = GROUP_W * GROUPS;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("R1 total mismatch");
      assert_cout_R4: assert (cout == gc[GROUPS]) else $error("R4 cout not top carry");
      for (int k = 0; k < GROUPS; k++) begin
        if (grp_g[k]) begin
          assert_gen_forces_R4: assert (gc[k+1]) else $error("R4 generate ignored");
        end
        if (!grp_g[k] && !grp_p[k]) begin
          assert_kill_blocks_R4: assert (!gc[k+1]) else $error("R4 carry leaked");
        end
        if (grp_p[k] && !grp_g[k]) begin
          assert_prop_passes_R4: assert (gc[k+1] == gc[k]) else $error("R4 propagate lost");
        end
      end
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grp_p(grp_p), .grp_g(grp_g), .gc(gc)
);

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] a, b, sum;
  logic cin, cout;
  logic [3:0] grp_p, grp_g;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cla_adder16 u_dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .grp_p(grp_p), .grp_g(grp_g)
  );

  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {16'h1A33, 16'hE5EB, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1},
    {16'h0000, 16'h0000, 1'b0},
    {16'hAAAA, 16'h5555, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1},
    {16'hAAAA, 16'hAAAA, 1'b1},
    {16'h5555, 16'h5555, 1'b0},
    {16'h0F0F, 16'h00F1, 1'b0},
    {16'h0F0F, 16'h00F1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_p(input logic [15:0] x, input logic [15:0] y);
    logic [15:0] o;
    o = x | y;
    for (int k = 0; k < 4; k++) exp_p[k] = (o[k*4 +: 4] == 4'hF);
  endfunction

  function automatic logic [3:0] exp_g(input logic [15:0] x, input logic [15:0] y);
    for (int k = 0; k < 4; k++) exp_g[k] = ({1'b0, x[k*4 +: 4]} + {1'b0, y[k*4 +: 4]}) > 5'd15;
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [16:0] e;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {16'd0, c};
    chk({cout, sum} == e, "R1", {15'd0, cout, sum}, {15'd0, e});
    chk(grp_p == exp_p(x, y), "R2", {28'd0, grp_p}, {28'd0, exp_p(x, y)});
    chk(grp_g == exp_g(x, y), "R3", {28'd0, grp_g}, {28'd0, exp_g(x, y)});
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sum == 16'h0 && cout == 1'b0 && grp_p == 4'h0 && grp_g == 4'h0, "R6 idle",
        {11'd0, cout, grp_p, sum}, 32'd0);

    for (int i = 0; i < NV; i++) apply(VEC[i][32:17], VEC[i][16:1], VEC[i][0]);

    apply(16'h1A33, 16'hE5EB, 1'b0);
    chk(grp_p == 4'b1110, "R5 P", {28'd0, grp_p}, 32'hE);
    chk(grp_g == 4'b0010, "R5 G", {28'd0, grp_g}, 32'h2);
    chk(sum == 16'h001E && cout, "R5 sum", {15'd0, cout, sum}, 32'h1001E);

    apply(16'hFFFF, 16'h0001, 1'b0);
    chk(sum == 16'h0 && cout, "R6 ones+1", {15'd0, cout, sum}, 32'h10000);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk(sum == 16'h0 && cout, "R6 ones+cin", {15'd0, cout, sum}, 32'h10000);
    apply(16'h0000, 16'h0000, 1'b0);
    chk(sum == 16'h0 && !cout, "R6 zero", {15'd0, cout, sum}, 32'h0);

    // R4: nibble 0 generates (8+8); nibble 1 propagates; carry must reach nibble 2
    for (int c = 0; c < 2; c++) begin
      apply(16'h00F8, 16'h0008, c[0]);
      chk(sum == (16'h0100 + c[15:0]), "R4 gen through prop", {16'd0, sum}, {16'd0, 16'h0100 + c[15:0]});
    end
    // R4: nibble 0 blocks (neither set): cin must not reach nibble 1
    apply(16'h00F0, 16'h0000, 1'b1);
    chk(sum == 16'h00F1 && !cout, "R4 kill", {15'd0, cout, sum}, 32'h00F1);
    // R4: all propagate, no generate: cin ripples to cout via lookahead
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    chk(sum == 16'h0 && cout, "R4 pass", {15'd0, cout, sum}, 32'h10000);

    // R7: both operand bits set in bit 0 -> sum bit 0 follows cin
    apply(16'h0001, 16'h0001, 1'b0);
    chk(sum[0] == 1'b0 && sum == 16'h0002, "R7 cin0", {16'd0, sum}, 32'h2);
    apply(16'h0001, 16'h0001, 1'b1);
    chk(sum[0] == 1'b1 && sum == 16'h0003, "R7 cin1", {16'd0, sum}, 32'h3);

    for (int i = 0; i < 3000; i++)
      apply($urandom()%65536, $urandom()%65536, $urandom()%2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule